// File: doc/BRIEF.md
# I/O Page Address Decoder for an 8-bit CPU Bus

This controller sits between an 8-bit processor bus and a 256-byte RAM. It splits the address space into two regions. The sixteen addresses at the top of the map, `$F0` to `$FF`, form an I/O page. Every address below that belongs to RAM. For any access into the I/O page the RAM chip-select stays low, so the RAM neither drives read data nor accepts a write there.

Inside the page there are four kinds of target:

- Two write-only output latches:
  - a LED bank at `$F0`;
  - a byte at `$F1`, shown as two hex digits on a seven-segment display.
- Two read-only input ports:
  - eight switches at `$F3`;
  - a single push button at `$F4`.
- An eight-row framebuffer window at `$F8` to `$FF`. Each address in the window is one row, and the row's most significant bit is the leftmost pixel.

The controller does not hold the framebuffer memory. It passes the row index and the write strobe out to that memory, and it passes the memory's row value back to the CPU. A per-bit read multiplexer picks the byte the CPU sees: switches, button, framebuffer row or RAM.

Top module: `mmio_page_ctrl`

## Requirements
- R1: `ram_cs` is 1 exactly when an access is requested (`cpu_re` or `cpu_we` is 1) and the address is outside `$F0`–`$FF`. It is 0 for every address in the page and when the bus is idle.
- R2: A write strobe to `$F0` loads `cpu_wdata` into `led_q` at the next rising clock edge.
- R3: A write strobe to `$F1` loads `cpu_wdata` into `seg_q` at the next rising clock edge. Bits [7:4] hold the left hex digit and bits [3:0] the right.
- R4: After reset, `led_q` and `seg_q` are 0. They keep their value on every edge that has no write strobe to their own address. This includes writes to `$F2`, `$F5`–`$F7`, the framebuffer window and RAM, and reads of `$F0`.
- R5: A read of `$F3` returns `sw_in` unchanged on `cpu_rdata`.
- R6: A read of `$F4` returns the button in bit 0 and zero in bits [7:1].
- R7: A read of `$F0`, `$F1`, `$F2`, `$F5`, `$F6` or `$F7` returns zero.
- R8: For an access to `$F8`–`$FF`:
  - `fb_sel` is 1;
  - `fb_row` equals address bits [2:0];
  - `fb_we` follows `cpu_we`;
  - a read returns `fb_rdata`.
- R9: A read outside the I/O page returns `ram_rdata`.
- R10: While `cpu_re` is 0, `cpu_rdata` is zero.
- R11: `fb_sel` and `fb_we` are 0 outside the framebuffer window, and `ram_cs` and `fb_sel` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_we | input | 1 | Write strobe |
| cpu_re | input | 1 | Read request |
| sw_in | input | DATA_W | Switch inputs |
| btn_in | input | 1 | Button level |
| ram_rdata | input | DATA_W | Byte returned by the RAM |
| fb_rdata | input | DATA_W | Row returned by the framebuffer |
| led_q | output | DATA_W | LED latch |
| seg_q | output | DATA_W | Seven-segment value latch |
| ram_cs | output | 1 | RAM chip-select |
| fb_sel | output | 1 | Framebuffer select |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_row | output | 3 | Framebuffer row index |
| cpu_rdata | output | DATA_W | Read data returned to the CPU |

## Verification
The bench uses the default parameters, `ADDR_W = 8` and `DATA_W = 8`. With these values the page boundary falls at `$EF`/`$F0`, the last RAM byte below the page and both ends of the framebuffer window are concrete addresses the bench can drive. Eight-bit data lets distinct patterns on the switches, RAM and framebuffer show which source the multiplexer picked. It also shows whether the button lands in bit 0 alone.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

    // Width of the in-page offset; the page is the top 2**OFS_W addresses.
    localparam int OFS_W = 4;
    // Row index width of the framebuffer window (upper half of the page).
    localparam int ROW_W = OFS_W - 1;

    localparam logic [OFS_W-1:0] OFS_LED = 4'h0;
    localparam logic [OFS_W-1:0] OFS_SEG = 4'h1;
    localparam logic [OFS_W-1:0] OFS_SW  = 4'h3;
    localparam logic [OFS_W-1:0] OFS_BTN = 4'h4;

    typedef enum logic [2:0] {
        TGT_RAM,
        TGT_LED,
        TGT_SEG,
        TGT_SW,
        TGT_BTN,
        TGT_FB,
        TGT_NONE
    } tgt_e;

    typedef struct packed {
        logic             active;
        tgt_e             tgt;
        logic [ROW_W-1:0] row;
    } dec_t;

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              re,
    input  logic              we,
    output dec_t              dec
);

    localparam int TAG_W = ADDR_W - OFS_W;

    logic             in_page;
    logic [OFS_W-1:0] ofs;

    assign in_page = &addr[ADDR_W-1 -: TAG_W];
    assign ofs     = addr[OFS_W-1:0];

    always_comb begin
        dec.active = re | we;
        dec.row    = ofs[ROW_W-1:0];
        if (!in_page) begin
            dec.tgt = TGT_RAM;
        end else if (ofs[OFS_W-1]) begin
            dec.tgt = TGT_FB;
        end else begin
            unique case (ofs)
                OFS_LED: dec.tgt = TGT_LED;
                OFS_SEG: dec.tgt = TGT_SEG;
                OFS_SW:  dec.tgt = TGT_SW;
                OFS_BTN: dec.tgt = TGT_BTN;
                default: dec.tgt = TGT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mmio_out_regs.sv
module mmio_out_regs
    import mmio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] led_q,
    output logic [DATA_W-1:0] seg_q
);

    typedef struct packed {
        logic [DATA_W-1:0] led;
        logic [DATA_W-1:0] seg;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (tgt)
                TGT_LED: st_d.led = wdata;
                TGT_SEG: st_d.seg = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign led_q = st_q.led;
    assign seg_q = st_q.seg;

endmodule

// File: rtl/mmio_rd_mux.sv
module mmio_rd_mux
    import mmio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              re,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] sw,
    input  logic              btn,
    input  logic [DATA_W-1:0] ram_d,
    input  logic [DATA_W-1:0] fb_d,
    output logic [DATA_W-1:0] rdata
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic btn_bit;
        logic bit_o;

        if (b == 0) begin : g_btn
            assign btn_bit = btn;
        end else begin : g_zero
            assign btn_bit = 1'b0;
        end

        always_comb begin
            bit_o = 1'b0;
            if (re) begin
                case (tgt)
                    TGT_RAM: bit_o = ram_d[b];
                    TGT_SW:  bit_o = sw[b];
                    TGT_BTN: bit_o = btn_bit;
                    TGT_FB:  bit_o = fb_d[b];
                    default: bit_o = 1'b0;
                endcase
            end
        end

        assign rdata[b] = bit_o;
    end

endmodule

// File: rtl/mmio_page_ctrl.sv
module mmio_page_ctrl
    import mmio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    input  logic              cpu_re,
    input  logic [DATA_W-1:0] sw_in,
    input  logic              btn_in,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] fb_rdata,
    output logic [DATA_W-1:0] led_q,
    output logic [DATA_W-1:0] seg_q,
    output logic              ram_cs,
    output logic              fb_sel,
    output logic              fb_we,
    output logic [ROW_W-1:0]  fb_row,
    output logic [DATA_W-1:0] cpu_rdata
);

    dec_t dec;

    mmio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (cpu_addr),
        .re   (cpu_re),
        .we   (cpu_we),
        .dec  (dec)
    );

    mmio_out_regs #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cpu_we),
        .tgt   (dec.tgt),
        .wdata (cpu_wdata),
        .led_q (led_q),
        .seg_q (seg_q)
    );

    mmio_rd_mux #(.DATA_W(DATA_W)) u_mux (
        .re    (cpu_re),
        .tgt   (dec.tgt),
        .sw    (sw_in),
        .btn   (btn_in),
        .ram_d (ram_rdata),
        .fb_d  (fb_rdata),
        .rdata (cpu_rdata)
    );

    assign ram_cs = dec.active && (dec.tgt == TGT_RAM);
    assign fb_sel = dec.active && (dec.tgt == TGT_FB);
    assign fb_we  = cpu_we && (dec.tgt == TGT_FB);
    assign fb_row = dec.row;

endmodule

// File: rtl/mmio_page_ctrl_chk.sv
module mmio_page_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_we,
    input logic              cpu_re,
    input logic [DATA_W-1:0] led_q,
    input logic [DATA_W-1:0] seg_q,
    input logic              ram_cs,
    input logic              fb_sel,
    input logic [DATA_W-1:0] cpu_rdata
);

    localparam logic [ADDR_W-1:0] A_LED = {{(ADDR_W-4){1'b1}}, 4'h0};
    localparam logic [ADDR_W-1:0] A_SEG = {{(ADDR_W-4){1'b1}}, 4'h1};

    // R1
    ram_cs_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> !(&cpu_addr[ADDR_W-1:4]));

    // R2
    led_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == A_LED) |=> led_q == $past(cpu_wdata));

    // R3
    seg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == A_SEG) |=> seg_q == $past(cpu_wdata));

    // R4
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && cpu_addr == A_LED) |=> $stable(led_q));

    // R4
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && cpu_addr == A_SEG) |=> $stable(seg_q));

    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_re |-> cpu_rdata == '0);

    // R11
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_cs && fb_sel));

endmodule

bind mmio_page_ctrl mmio_page_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .cpu_re    (cpu_re),
    .led_q     (led_q),
    .seg_q     (seg_q),
    .ram_cs    (ram_cs),
    .fb_sel    (fb_sel),
    .cpu_rdata (cpu_rdata)
);

// File: tb/mmio_page_ctrl_test.sv
module mmio_page_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_we = 1'b0;
    logic       cpu_re = 1'b0;
    logic [7:0] sw_in = '0;
    logic       btn_in = 1'b0;
    logic [7:0] ram_rdata = '0;
    logic [7:0] fb_rdata = '0;
    logic [7:0] led_q, seg_q, cpu_rdata;
    logic       ram_cs, fb_sel, fb_we;
    logic [2:0] fb_row;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mmio_page_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_re(cpu_re), .sw_in(sw_in), .btn_in(btn_in),
        .ram_rdata(ram_rdata), .fb_rdata(fb_rdata), .led_q(led_q), .seg_q(seg_q),
        .ram_cs(ram_cs), .fb_sel(fb_sel), .fb_we(fb_we), .fb_row(fb_row),
        .cpu_rdata(cpu_rdata)
    );

    typedef struct packed {
        logic [7:0] addr;
        logic       we;
        logic       re;
        logic [7:0] sw;
        logic       btn;
        logic [7:0] ramd;
        logic [7:0] fbd;
        logic [7:0] exp_rd;
        logic       exp_cs;
        logic       exp_fs;
        logic       exp_fwe;
        logic [2:0] exp_row;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // addr   we    re    sw     btn   ramd   fbd    rd     cs    fs    fwe   row   tag
        '{8'h10, 1'b0, 1'b1, 8'h5A, 1'b1, 8'h77, 8'hC3, 8'h77, 1'b1, 1'b0, 1'b0, 3'd0, 4'd9},  // R9 RAM read
        '{8'hEF, 1'b0, 1'b1, 8'h5A, 1'b1, 8'h77, 8'hC3, 8'h77, 1'b1, 1'b0, 1'b0, 3'd7, 4'd9},  // R9 last RAM byte
        '{8'hF3, 1'b0, 1'b1, 8'h5A, 1'b1, 8'h77, 8'hC3, 8'h5A, 1'b0, 1'b0, 1'b0, 3'd3, 4'd5},  // R5 switches
        '{8'hF4, 1'b0, 1'b1, 8'h5A, 1'b1, 8'h77, 8'hC3, 8'h01, 1'b0, 1'b0, 1'b0, 3'd4, 4'd6},  // R6 button high
        '{8'hF4, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h77, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b0, 3'd4, 4'd6},  // R6 button low
        '{8'hF2, 1'b0, 1'b1, 8'h5A, 1'b1, 8'h77, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b0, 3'd2, 4'd7},  // R7 unused
        '{8'hF7, 1'b0, 1'b1, 8'h5A, 1'b1, 8'h77, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b0, 3'd7, 4'd7},  // R7 unused
        '{8'hF0, 1'b0, 1'b1, 8'h5A, 1'b1, 8'h77, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 4'd7},  // R7 write-only latch
        '{8'hF8, 1'b0, 1'b1, 8'h5A, 1'b1, 8'h77, 8'hC3, 8'hC3, 1'b0, 1'b1, 1'b0, 3'd0, 4'd8},  // R8 first row
        '{8'hFF, 1'b0, 1'b1, 8'h5A, 1'b1, 8'h77, 8'h3C, 8'h3C, 1'b0, 1'b1, 1'b0, 3'd7, 4'd8},  // R8 last row
        '{8'hFD, 1'b1, 1'b0, 8'h5A, 1'b1, 8'h77, 8'hC3, 8'h00, 1'b0, 1'b1, 1'b1, 3'd5, 4'd8},  // R8 row write, R10
        '{8'hF3, 1'b0, 1'b0, 8'h5A, 1'b1, 8'h77, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b0, 3'd3, 4'd10}, // R10 no read
        '{8'h20, 1'b1, 1'b0, 8'h5A, 1'b1, 8'h77, 8'hC3, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 4'd1},  // R1 RAM write
        '{8'h00, 1'b0, 1'b0, 8'h5A, 1'b1, 8'h77, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 4'd1},  // R1 idle
        '{8'hFA, 1'b0, 1'b1, 8'h5A, 1'b1, 8'h77, 8'hC3, 8'hC3, 1'b0, 1'b1, 1'b0, 3'd2, 4'd11}  // R11 read no fb_we
    };

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1; cpu_re = 1'b0;
        @(negedge clk);
        cpu_we = 1'b0;
        #5;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        chk("R4", "led after reset", led_q, 8'h00);
        chk("R4", "seg after reset", seg_q, 8'h00);
        rst_n = 1'b1;
        @(negedge clk); #5;
        chk("R1", "idle ram_cs", {7'd0, ram_cs}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cpu_addr = VECS[i].addr; cpu_we = VECS[i].we; cpu_re = VECS[i].re;
            cpu_wdata = 8'hEE;
            sw_in = VECS[i].sw; btn_in = VECS[i].btn;
            ram_rdata = VECS[i].ramd; fb_rdata = VECS[i].fbd;
            #5;
            chk($sformatf("R%0d", VECS[i].tag), $sformatf("v%0d rdata", i), cpu_rdata, VECS[i].exp_rd);
            chk("R1", $sformatf("v%0d ram_cs", i), {7'd0, ram_cs}, {7'd0, VECS[i].exp_cs});
            chk("R11", $sformatf("v%0d fb_sel", i), {7'd0, fb_sel}, {7'd0, VECS[i].exp_fs});
            chk("R11", $sformatf("v%0d fb_we", i), {7'd0, fb_we}, {7'd0, VECS[i].exp_fwe});
            if (VECS[i].exp_fs) chk("R8", $sformatf("v%0d fb_row", i), {5'd0, fb_row}, {5'd0, VECS[i].exp_row});
        end
        @(negedge clk);
        cpu_we = 1'b0; cpu_re = 1'b0;
        #5;
        chk("R4", "led after vectors", led_q, 8'h00);
        chk("R4", "seg after vectors", seg_q, 8'h00);

        wr(8'hF0, 8'hA5);
        chk("R2", "led load", led_q, 8'hA5);
        chk("R4", "seg untouched by led write", seg_q, 8'h00);
        wr(8'hF1, 8'h3C);
        chk("R3", "seg load", seg_q, 8'h3C);
        chk("R4", "led untouched by seg write", led_q, 8'hA5);

        wr(8'hF2, 8'hFF);
        wr(8'hF5, 8'hFF);
        wr(8'hF6, 8'hFF);
        wr(8'hF7, 8'hFF);
        wr(8'hF8, 8'hFF);
        wr(8'h30, 8'hFF);
        chk("R4", "led after stray writes", led_q, 8'hA5);
        chk("R4", "seg after stray writes", seg_q, 8'h3C);

        @(negedge clk);
        cpu_addr = 8'hF0; cpu_wdata = 8'h00; cpu_re = 1'b1; cpu_we = 1'b0;
        @(negedge clk);
        cpu_re = 1'b0;
        #5;
        chk("R4", "led after read of its address", led_q, 8'hA5);

        @(negedge clk);
        cpu_addr = 8'hF0; cpu_wdata = 8'h01; cpu_we = 1'b1;
        @(negedge clk);
        cpu_wdata = 8'h80;
        #5;
        chk("R2", "led first of back-to-back", led_q, 8'h01);
        @(negedge clk);
        cpu_we = 1'b0;
        #5;
        chk("R2", "led second of back-to-back", led_q, 8'h80);

        rst_n = 1'b0;
        #5;
        chk("R4", "led after mid-run reset", led_q, 8'h00);
        chk("R4", "seg after mid-run reset", seg_q, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule